// File: doc/BRIEF.md
# Serial Target Front End for a Clock Register File

This block lets an external serial host reach a bank of sixteen byte-wide
timekeeping registers over a four-wire serial link. The host raises an
active-high enable, clocks in one command byte that selects the direction and
a starting register, then moves any number of data bytes. After every data
byte the register pointer steps up by one, and it wraps from the last register
to the first, so a host can load or fetch a whole block of registers in one
burst.

All link signals are brought into the system clock domain through two-flop
synchronisers, and serial clock edges are found there. On the write side the
block hands the register bank a single-cycle strobe with address and data. On
the read side it presents an address to the bank, takes the byte back and
shifts it out MSB first, changing the output after falling serial clock edges
(clock idle low, sampling on rising edges). A command byte without its fixed
marker bit voids the rest of the transaction. One specific byte written to
the first control register is not passed on as data; it becomes a one-cycle
reset pulse instead.

Top module: `spi_rtc_front`

## Requirements
- R1: Out of reset, with the enable low, `reg_we` and `soft_rst` are low and `miso` is 0.
- R2: The first byte of a transaction is the command: bit 7 = 1 selects read, 0 selects write; bit 4 must be 1; bits 3:0 are the start address. In a write, each completed data byte gives exactly one cycle of `reg_we` with `reg_waddr` equal to the current pointer and `reg_wdata` equal to the byte (received MSB first).
- R3: The pointer increments by one after every data byte and wraps from 0xF to 0x0, so a write burst of N bytes from address A writes addresses A, A+1, ... modulo 16 in order.
- R4: In a read, `reg_raddr` carries the pointer, and each data byte on `miso` is the value of `reg_rdata` for that address, MSB first; the burst follows the same increment and wrap as R3.
- R5: A command byte with bit 4 clear makes the rest of that transaction have no effect: no `reg_we`, no `soft_rst`, and `miso` stays 0.
- R6: A write of data 0x58 to address 0x0 gives one cycle of `soft_rst` and no `reg_we`; 0x58 to any other address, or any other value to address 0x0, is an ordinary write.
- R7: Serial clock edges while the enable is low have no effect; dropping the enable discards a partial byte, and the next transaction starts again with a command byte.
- R8: If the final rising serial clock edge of a byte reaches the block in the same synchronised cycle as the enable falling, that byte is discarded and produces no write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host, idle low |
| cs_en | input | 1 | Transaction enable, active high |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host, 0 when not reading |
| reg_raddr | output | 4 | Read address presented to the register bank |
| reg_rdata | input | 8 | Read data returned by the register bank |
| reg_we | output | 1 | Single-cycle write strobe to the register bank |
| reg_waddr | output | 4 | Write address, valid with `reg_we` |
| reg_wdata | output | 8 | Write data, valid with `reg_we` |
| soft_rst | output | 1 | Single-cycle reset pulse from the reset pattern write |

## Verification
The two events that can land in one system clock cycle are the completion of a byte on the last rising serial clock edge and the end of the transaction as the enable falls. The bench provokes this by driving the eighth rising serial clock edge and the enable drop at the same instant, so that both pass through identical synchroniser chains and arrive together, and judges it by watching that no write strobe appears for that byte. A follow-up transaction then confirms that the block restarted cleanly at the command byte.

// File: rtl/spi_rtc_pkg.sv
package spi_rtc_pkg;

    localparam int ADDR_W      = 4;
    localparam int DATA_W      = 8;
    localparam int CNT_W       = $clog2(DATA_W);
    localparam int CMD_RD_BIT  = 7;
    localparam int CMD_MK_BIT  = 4;
    localparam int LINK_W      = 3;

    localparam logic [ADDR_W-1:0] CTRL_A_ADDR   = '0;
    localparam logic [DATA_W-1:0] SOFT_RST_CODE = 8'h58;

    typedef enum logic [1:0] {
        ST_CMD  = 2'd0,
        ST_DATA = 2'd1,
        ST_DROP = 2'd2
    } xfer_state_e;

    typedef struct packed {
        logic              is_read;
        logic              marker;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    typedef struct packed {
        logic mosi;
        logic cs;
        logic sclk;
    } link_t;

    function automatic cmd_t decode_cmd(input logic rd_bit, input logic mk_bit,
                                        input logic [ADDR_W-1:0] a);
        cmd_t c;
        c.is_read = rd_bit;
        c.marker  = mk_bit;
        c.addr    = a;
        return c;
    endfunction

    function automatic logic is_soft_reset(input logic [ADDR_W-1:0] a,
                                           input logic [DATA_W-1:0] d);
        return (a == CTRL_A_ADDR) && (d == SOFT_RST_CODE);
    endfunction

endpackage

// File: rtl/spi_rtc_sync.sv
module spi_rtc_sync
    import spi_rtc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic cs_en,
    input  logic mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_live,
    output logic mosi_s
);

    link_t chain [STAGES];
    logic  sclk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain[0] <= '0;
        end else begin
            chain[0] <= '{mosi: mosi, cs: cs_en, sclk: sclk};
        end
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[g] <= '0;
                end else begin
                    chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_prev <= 1'b0;
        end else begin
            sclk_prev <= chain[STAGES-1].sclk;
        end
    end

    assign sclk_rise = chain[STAGES-1].sclk & ~sclk_prev;
    assign sclk_fall = ~chain[STAGES-1].sclk & sclk_prev;
    assign cs_live   = chain[STAGES-1].cs;
    assign mosi_s    = chain[STAGES-1].mosi;

endmodule

// File: rtl/spi_rtc_shifter.sv
module spi_rtc_shifter
    import spi_rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_live,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              mosi_s,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_data,
    output logic              byte_done,
    output logic [DATA_W-1:0] rx_byte,
    output logic              miso
);

    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-2:0] rx_sh;
    logic [DATA_W-1:0] tx_sh;

    // receive side: sample on rising edges
    always_ff @(posedge clk) begin
        if (rst || !cs_live) begin
            bit_cnt   <= '0;
            rx_sh     <= '0;
            byte_done <= 1'b0;
            rx_byte   <= '0;
        end else begin
            byte_done <= 1'b0;
            if (sclk_rise) begin
                bit_cnt <= bit_cnt + 1'b1;
                rx_sh   <= {rx_sh[DATA_W-3:0], mosi_s};
                if (bit_cnt == CNT_W'(DATA_W-1)) begin
                    byte_done <= 1'b1;
                    rx_byte   <= {rx_sh, mosi_s};
                end
            end
        end
    end

    // transmit side: change on falling edges, reload at byte boundary
    always_ff @(posedge clk) begin
        if (rst || !cs_live) begin
            tx_sh <= '0;
        end else if (sclk_fall) begin
            if (bit_cnt == '0) begin
                tx_sh <= load_en ? load_data : '0;
            end else begin
                tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
            end
        end
    end

    assign miso = tx_sh[DATA_W-1];

endmodule

// File: rtl/spi_rtc_ctrl.sv
module spi_rtc_ctrl
    import spi_rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_live,
    input  logic              byte_done,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              data_phase,
    output logic              tx_read,
    output logic [ADDR_W-1:0] ptr,
    output logic              reg_we,
    output logic [ADDR_W-1:0] reg_waddr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              soft_rst
);

    xfer_state_e state;
    logic        rd_mode;
    cmd_t        cmd;

    always_comb begin
        cmd = decode_cmd(rx_byte[CMD_RD_BIT], rx_byte[CMD_MK_BIT],
                         rx_byte[ADDR_W-1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst || !cs_live) begin
            state    <= ST_CMD;
            rd_mode  <= 1'b0;
            ptr      <= '0;
            reg_we   <= 1'b0;
            soft_rst <= 1'b0;
        end else begin
            reg_we   <= 1'b0;
            soft_rst <= 1'b0;
            if (byte_done) begin
                unique case (state)
                    ST_CMD: begin
                        if (cmd.marker) begin
                            state   <= ST_DATA;
                            rd_mode <= cmd.is_read;
                            ptr     <= cmd.addr;
                        end else begin
                            state <= ST_DROP;
                        end
                    end
                    ST_DATA: begin
                        if (!rd_mode) begin
                            if (is_soft_reset(ptr, rx_byte)) begin
                                soft_rst <= 1'b1;
                            end else begin
                                reg_we <= 1'b1;
                            end
                        end
                        ptr <= ptr + 1'b1;
                    end
                    default: state <= ST_DROP;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_waddr <= '0;
            reg_wdata <= '0;
        end else if (cs_live && byte_done && state == ST_DATA && !rd_mode) begin
            reg_waddr <= ptr;
            reg_wdata <= rx_byte;
        end
    end

    assign data_phase = (state == ST_DATA);
    assign tx_read    = data_phase && rd_mode;

endmodule

// File: rtl/spi_rtc_front.sv
module spi_rtc_front
    import spi_rtc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              cs_en,
    input  logic              mosi,
    output logic              miso,
    output logic [ADDR_W-1:0] reg_raddr,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              reg_we,
    output logic [ADDR_W-1:0] reg_waddr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              soft_rst
);

    logic              sclk_rise;
    logic              sclk_fall;
    logic              cs_live;
    logic              mosi_s;
    logic              byte_done;
    logic [DATA_W-1:0] rx_byte;
    logic              data_phase;
    logic              tx_read;

    spi_rtc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .sclk      (sclk),
        .cs_en     (cs_en),
        .mosi      (mosi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_live   (cs_live),
        .mosi_s    (mosi_s)
    );

    spi_rtc_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .cs_live   (cs_live),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .mosi_s    (mosi_s),
        .load_en   (tx_read),
        .load_data (reg_rdata),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .miso      (miso)
    );

    spi_rtc_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cs_live    (cs_live),
        .byte_done  (byte_done),
        .rx_byte    (rx_byte),
        .data_phase (data_phase),
        .tx_read    (tx_read),
        .ptr        (reg_raddr),
        .reg_we     (reg_we),
        .reg_waddr  (reg_waddr),
        .reg_wdata  (reg_wdata),
        .soft_rst   (soft_rst)
    );

endmodule

// File: rtl/spi_rtc_checker.sv
module spi_rtc_checker
    import spi_rtc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cs_live,
    input logic              byte_done,
    input logic              data_phase,
    input logic              miso,
    input logic              reg_we,
    input logic              soft_rst,
    input logic [ADDR_W-1:0] reg_raddr
);

    p_we_single_r2: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    p_we_after_byte_r2: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> $past(byte_done) && $past(cs_live));

    p_ptr_step_r3: assert property (@(posedge clk) disable iff (rst)
        (cs_live && byte_done && data_phase) |=>
            (!cs_live || reg_raddr == $past(reg_raddr) + 1'b1));

    p_no_we_with_reset_r6: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && soft_rst));

    p_soft_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> !soft_rst);

    p_quiet_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !cs_live |=> !miso && !reg_we && !soft_rst);

endmodule

bind spi_rtc_front spi_rtc_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_live    (cs_live),
    .byte_done  (byte_done),
    .data_phase (data_phase),
    .miso       (miso),
    .reg_we     (reg_we),
    .soft_rst   (soft_rst),
    .reg_raddr  (reg_raddr)
);

// File: tb/sim_spi_rtc_front.sv
`timescale 1ns/1ps
module sim_spi_rtc_front;

    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sclk = 1'b0;
    logic       cs_en = 1'b0;
    logic       mosi = 1'b0;
    logic       miso;
    logic [3:0] reg_raddr;
    logic [7:0] reg_rdata;
    logic       reg_we;
    logic [3:0] reg_waddr;
    logic [7:0] reg_wdata;
    logic       soft_rst;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [3:0] log_a [64];
    logic [7:0] log_d [64];
    int         n_wr = 0;
    int         n_sr = 0;
    int         miso_ones = 0;

    always #2.5 clk = ~clk;

    spi_rtc_front u0 (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_en(cs_en), .mosi(mosi),
        .miso(miso), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
        .soft_rst(soft_rst)
    );

    function automatic logic [7:0] bank_val(input int i);
        return 8'((i % 16) * 37 + 5);
    endfunction

    assign reg_rdata = bank_val(int'(reg_raddr));

    always @(negedge clk) begin
        if (!rst) begin
            if (reg_we) begin
                if (n_wr < 64) begin
                    log_a[n_wr] = reg_waddr;
                    log_d[n_wr] = reg_wdata;
                end
                n_wr++;
            end
            if (soft_rst) n_sr++;
            if (miso) miso_ones++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_log();
        n_wr = 0; n_sr = 0; miso_ones = 0;
    endtask

    task automatic open_x();
        cs_en = 1'b1;
        clks(HALF);
    endtask

    task automatic close_x();
        clks(HALF);
        cs_en = 1'b0;
        clks(10);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int b = 7; b >= 0; b--) begin
            mosi = tx[b];
            clks(HALF);
            rx[b] = miso;
            sclk = 1'b1;
            clks(HALF);
            sclk = 1'b0;
        end
    endtask

    task automatic write_one(input logic [3:0] a, input logic [7:0] d);
        logic [7:0] rx;
        open_x();
        xfer(8'h10 | 8'(a), rx);
        xfer(d, rx);
        close_x();
    endtask

    initial begin
        logic [7:0] rx;
        clks(4);
        rst = 1'b0;
        clks(4);

        // R1 reset state
        chk(miso == 1'b0, "R1 miso", int'(miso), 0);
        chk(reg_we == 1'b0 && soft_rst == 1'b0, "R1 strobes", int'({reg_we, soft_rst}), 0);

        // R2 single write at every address
        for (int a = 0; a < 16; a++) begin
            clear_log();
            write_one(4'(a), 8'(a * 13 + 7));
            chk(n_wr == 1, "R2 count", n_wr, 1);
            chk(log_a[0] == 4'(a), "R2 addr", int'(log_a[0]), a);
            chk(log_d[0] == 8'(a * 13 + 7), "R2 data", int'(log_d[0]), (a * 13 + 7) % 256);
        end

        // R3 burst of 7 from 0x2, then wrap burst of 4 from 0xE
        clear_log();
        open_x();
        xfer(8'h12, rx);
        for (int k = 0; k < 7; k++) xfer(8'(8'hA0 + k), rx);
        close_x();
        chk(n_wr == 7, "R3 burst count", n_wr, 7);
        for (int k = 0; k < 7; k++) begin
            chk(log_a[k] == 4'(2 + k) && log_d[k] == 8'(8'hA0 + k), "R3 burst",
                int'({log_a[k], log_d[k]}), int'({4'(2 + k), 8'(8'hA0 + k)}));
        end
        clear_log();
        open_x();
        xfer(8'h1E, rx);
        for (int k = 0; k < 4; k++) xfer(8'(8'h30 + k), rx);
        close_x();
        chk(n_wr == 4, "R3 wrap count", n_wr, 4);
        for (int k = 0; k < 4; k++) begin
            chk(log_a[k] == 4'((14 + k) % 16), "R3 wrap addr", int'(log_a[k]), (14 + k) % 16);
        end

        // R4 read bursts of 3 from every start address
        for (int s = 0; s < 16; s++) begin
            clear_log();
            open_x();
            xfer(8'h90 | 8'(s), rx);
            for (int k = 0; k < 3; k++) begin
                xfer(8'h00, rx);
                chk(rx == bank_val(s + k), "R4 read", int'(rx), int'(bank_val(s + k)));
            end
            close_x();
            chk(n_wr == 0, "R4 no write", n_wr, 0);
        end

        // R5 missing marker: write and read forms
        clear_log();
        open_x();
        xfer(8'h03, rx);
        xfer(8'h44, rx);
        xfer(8'h45, rx);
        close_x();
        chk(n_wr == 0 && n_sr == 0, "R5 write voided", n_wr + n_sr, 0);
        clear_log();
        open_x();
        xfer(8'h00, rx);
        xfer(8'h58, rx);
        close_x();
        chk(n_sr == 0, "R5 reset voided", n_sr, 0);
        clear_log();
        open_x();
        xfer(8'h85, rx);
        xfer(8'h00, rx);
        xfer(8'h00, rx);
        close_x();
        chk(miso_ones == 0, "R5 read silent", miso_ones, 0);

        // R6 reset pattern and near misses
        clear_log();
        write_one(4'h0, 8'h58);
        chk(n_sr == 1, "R6 pulse", n_sr, 1);
        chk(n_wr == 0, "R6 no write", n_wr, 0);
        clear_log();
        write_one(4'h3, 8'h58);
        chk(n_wr == 1 && n_sr == 0, "R6 other addr", n_wr * 16 + n_sr, 16);
        clear_log();
        write_one(4'h0, 8'h57);
        chk(n_wr == 1 && log_d[0] == 8'h57 && n_sr == 0, "R6 other value",
            int'(log_d[0]), 8'h57);
        clear_log();
        open_x();
        xfer(8'h1F, rx);
        xfer(8'h58, rx);
        xfer(8'h58, rx);
        close_x();
        chk(n_wr == 1 && log_a[0] == 4'hF, "R6 wrap write", n_wr * 16 + int'(log_a[0]), 16 + 15);
        chk(n_sr == 1, "R6 wrap pulse", n_sr, 1);

        // R7 clock while disabled, then partial byte
        clear_log();
        mosi = 1'b1;
        for (int k = 0; k < 8; k++) begin
            clks(HALF); sclk = 1'b1; clks(HALF); sclk = 1'b0;
        end
        chk(n_wr == 0 && miso_ones == 0, "R7 idle clocks", n_wr + miso_ones, 0);
        write_one(4'h6, 8'hC3);
        chk(n_wr == 1 && log_a[0] == 4'h6 && log_d[0] == 8'hC3, "R7 after idle",
            int'({log_a[0], log_d[0]}), int'({4'h6, 8'hC3}));
        clear_log();
        open_x();
        xfer(8'h15, rx);
        for (int b = 7; b >= 4; b--) begin
            mosi = 1'b1; clks(HALF); sclk = 1'b1; clks(HALF); sclk = 1'b0;
        end
        close_x();
        chk(n_wr == 0, "R7 partial", n_wr, 0);
        write_one(4'h7, 8'h3C);
        chk(n_wr == 1 && log_a[0] == 4'h7 && log_d[0] == 8'h3C, "R7 restart",
            int'({log_a[0], log_d[0]}), int'({4'h7, 8'h3C}));

        // R8 last edge coincides with enable drop
        clear_log();
        open_x();
        xfer(8'h19, rx);
        for (int b = 7; b >= 1; b--) begin
            mosi = 1'b1; clks(HALF); sclk = 1'b1; clks(HALF); sclk = 1'b0;
        end
        mosi = 1'b0;
        clks(HALF);
        sclk = 1'b1;
        cs_en = 1'b0;
        clks(HALF);
        sclk = 1'b0;
        clks(10);
        chk(n_wr == 0, "R8 discarded", n_wr, 0);
        write_one(4'h9, 8'h81);
        chk(n_wr == 1 && log_a[0] == 4'h9 && log_d[0] == 8'h81, "R8 restart",
            int'({log_a[0], log_d[0]}), int'({4'h9, 8'h81}));

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule